// File: doc/BRIEF.md
# Regulator Start-up Sequencer

This block orders the power-up of a multiphase voltage regulator. It waits for the supply's power-on-reset-good signal and an enable request, then raises a reference DAC code slowly from zero to a fixed boot level. Once there, it waits until a feedback "output in window" flag has been seen true on a run of consecutive PWM-cycle pulses. It then asserts an active-low clock-enable and moves the reference, twice as fast, to the target supplied on the VID input. Power-good rises once the sequencer is in that final phase and a programmable time has elapsed since the soft-start began.

All ramps advance on a one-microsecond timebase tick supplied from outside, so the rates are fixed in steps per tick: one 2.5 mV step per tick in soft-start and two steps per tick when slewing to VID. A strap input selects a mode where enable is treated as permanently high, and the soft-start is then delayed by a fixed number of ticks after power-on-reset becomes good. Losing either the supply or the enable request returns everything to idle at once. After start-up the DAC keeps following VID changes at the fast rate, and power-good stays asserted.

Top module: `vr_startup_seq`

## Requirements
- R1: After reset, and while power-on-reset-good is low or neither enable nor the strap is high, the DAC code is 0, clk_en_n is 1 and pgood is 0, and ticks have no effect.
- R2: In soft-start the DAC code rises by exactly 1 on each timebase tick until it equals BOOT_CODE, and then it holds there.
- R3: Qualification passes only after QUAL_CYCLES consecutive PWM-cycle pulses that each see in_window high; a pulse that sees in_window low restarts the count from zero, and clk_en_n stays 1 until the pass.
- R4: clk_en_n goes to 0 on the clock after the qualifying pulse is registered and stays 0 while the sequence is not aborted.
- R5: With clk_en_n low, each tick moves the DAC code toward vid_code by 2, or by 1 when it is only 1 away; it never overshoots and holds when equal. Later VID changes are followed the same way.
- R6: With en_strap high, en is ignored; the soft-start begins on the clock after STRAP_TICKS ticks have elapsed since power-on-reset-good was seen high, and the DAC stays 0 until then.
- R7: If power-on-reset-good drops, or en drops while en_strap is low, then on the next clock the DAC code is 0, clk_en_n is 1 and pgood is 0.
- R8: pgood is 1 exactly when clk_en_n is 0 and at least PGOOD_TICKS ticks have been counted since the soft-start began; it stays 1 through later VID changes.
- R9: While clk_en_n is 1 the DAC code never exceeds BOOT_CODE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_good | input | 1 | Supply power-on-reset condition is good |
| en | input | 1 | Regulator enable request |
| en_strap | input | 1 | Enable strapped high: ignore en, use delayed start |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| pwm_pulse | input | 1 | One-cycle pulse once per PWM cycle |
| in_window | input | 1 | Output is within the boot-voltage window |
| vid_code | input | DAC_W | Target DAC code from decoded VID |
| dac_code | output | DAC_W | Reference DAC code, 2.5 mV per step |
| clk_en_n | output | 1 | Active-low clock enable |
| pgood | output | 1 | Power-good |

## Verification
The assertions watch on every cycle that a supply or enable loss clears all three outputs on the next clock, that the DAC stays at or below the boot code while the clock-enable is high, that it moves by no more than two steps per cycle once tracking, that it does not move without a tick before qualification, and that clock-enable and power-good stay asserted and power-good never appears without clock-enable. Only the bench's scenarios can show the exact ramp values tick by tick, the restart of qualification after a pulse outside the window, the strap-mode delay length, the no-overshoot clamp on odd distances, and the exact tick on which power-good rises.

// File: rtl/vrseq_pkg.sv
package vrseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STRAP,
        ST_SOFT,
        ST_QUAL,
        ST_TRACK
    } seq_state_e;

    typedef enum logic {
        RAMP_SOFT,
        RAMP_TRACK
    } ramp_mode_e;

    typedef struct packed {
        logic       ramp_clr;
        logic       ramp_run;
        ramp_mode_e ramp_mode;
        logic       strap_run;
        logic       elapsed_clr;
        logic       elapsed_run;
        logic       qual_run;
    } seq_ctl_t;

    localparam int unsigned SOFT_STEP  = 1;
    localparam int unsigned TRACK_STEP = 2;

    // Move cur toward tgt by at most step, never past tgt.
    function automatic int unsigned approach(int unsigned cur,
                                             int unsigned tgt,
                                             int unsigned step);
        if (cur < tgt) begin
            return ((tgt - cur) > step) ? cur + step : tgt;
        end
        if (cur > tgt) begin
            return ((cur - tgt) > step) ? cur - step : tgt;
        end
        return cur;
    endfunction

endpackage

// File: rtl/vrseq_tick_cnt.sv
module vrseq_tick_cnt #(
    parameter int unsigned LIMIT = 120
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic run,
    input  logic tick,
    output logic done
);
    localparam int unsigned CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign done = (cnt_q == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run && tick && !done) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/vrseq_qual.sv
module vrseq_qual #(
    parameter int unsigned QUAL_CYCLES = 13
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic pwm_pulse,
    input  logic in_window,
    output logic pass
);
    localparam int unsigned QW = $clog2(QUAL_CYCLES + 1);

    logic [QW-1:0] run_q;

    assign pass = (run_q == QW'(QUAL_CYCLES));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            run_q <= '0;
        end else if (pwm_pulse) begin
            if (!in_window) begin
                run_q <= '0;
            end else if (!pass) begin
                run_q <= run_q + QW'(1);
            end
        end
    end
endmodule

// File: rtl/vrseq_ramp.sv
module vrseq_ramp
    import vrseq_pkg::*;
#(
    parameter int unsigned DAC_W     = 10,
    parameter int unsigned BOOT_CODE = 440
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             run,
    input  ramp_mode_e       mode,
    input  logic             tick,
    input  logic [DAC_W-1:0] target,
    output logic [DAC_W-1:0] code
);
    int unsigned goal;
    int unsigned step;
    int unsigned nxt;

    always_comb begin
        if (mode == RAMP_SOFT) begin
            goal = BOOT_CODE;
            step = SOFT_STEP;
        end else begin
            goal = 32'(target);
            step = TRACK_STEP;
        end
        nxt = approach(32'(code), goal, step);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            code <= '0;
        end else if (run && tick) begin
            code <= DAC_W'(nxt);
        end
    end
endmodule

// File: rtl/vr_startup_seq.sv
module vr_startup_seq
    import vrseq_pkg::*;
#(
    parameter int unsigned DAC_W       = 10,
    parameter int unsigned BOOT_CODE   = 440,
    parameter int unsigned QUAL_CYCLES = 13,
    parameter int unsigned STRAP_TICKS = 120,
    parameter int unsigned PGOOD_TICKS = 7000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             por_good,
    input  logic             en,
    input  logic             en_strap,
    input  logic             us_tick,
    input  logic             pwm_pulse,
    input  logic             in_window,
    input  logic [DAC_W-1:0] vid_code,
    output logic [DAC_W-1:0] dac_code,
    output logic             clk_en_n,
    output logic             pgood
);
    seq_state_e st_q, st_d;
    seq_ctl_t   ctl;
    logic       abort;
    logic       strap_done;
    logic       elapsed_done;
    logic       qual_pass;
    logic       at_boot;

    assign abort   = !por_good || (!en_strap && !en);
    assign at_boot = (dac_code == DAC_W'(BOOT_CODE));

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (por_good && en_strap) begin
                    st_d = ST_STRAP;
                end else if (por_good && en) begin
                    st_d = ST_SOFT;
                end
            end
            ST_STRAP: if (strap_done) st_d = ST_SOFT;
            ST_SOFT:  if (at_boot)    st_d = ST_QUAL;
            ST_QUAL:  if (qual_pass)  st_d = ST_TRACK;
            ST_TRACK: st_d = ST_TRACK;
            default:  st_d = ST_IDLE;
        endcase
        if (abort) begin
            st_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        ctl.ramp_clr    = abort || (st_q == ST_IDLE) || (st_q == ST_STRAP);
        ctl.ramp_run    = (st_q == ST_SOFT) || (st_q == ST_TRACK);
        ctl.ramp_mode   = (st_q == ST_TRACK) ? RAMP_TRACK : RAMP_SOFT;
        ctl.strap_run   = (st_q == ST_STRAP) && !abort;
        ctl.elapsed_run = (st_q == ST_SOFT) || (st_q == ST_QUAL) || (st_q == ST_TRACK);
        ctl.elapsed_clr = abort || !ctl.elapsed_run;
        ctl.qual_run    = (st_q == ST_QUAL) && !abort;
    end

    vrseq_tick_cnt #(.LIMIT(STRAP_TICKS)) u_strap_dly (
        .clk  (clk),
        .rst  (rst),
        .clr  (!ctl.strap_run),
        .run  (ctl.strap_run),
        .tick (us_tick),
        .done (strap_done)
    );

    vrseq_tick_cnt #(.LIMIT(PGOOD_TICKS)) u_pgood_dly (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctl.elapsed_clr),
        .run  (ctl.elapsed_run),
        .tick (us_tick),
        .done (elapsed_done)
    );

    vrseq_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
        .clk       (clk),
        .rst       (rst),
        .run       (ctl.qual_run),
        .pwm_pulse (pwm_pulse),
        .in_window (in_window),
        .pass      (qual_pass)
    );

    vrseq_ramp #(.DAC_W(DAC_W), .BOOT_CODE(BOOT_CODE)) u_ramp (
        .clk    (clk),
        .rst    (rst),
        .clr    (ctl.ramp_clr),
        .run    (ctl.ramp_run),
        .mode   (ctl.ramp_mode),
        .tick   (us_tick),
        .target (vid_code),
        .code   (dac_code)
    );

    assign clk_en_n = (st_q != ST_TRACK);
    assign pgood    = (st_q == ST_TRACK) && elapsed_done;
endmodule

// File: rtl/vr_startup_seq_chk.sv
module vr_startup_seq_chk #(
    parameter int unsigned DAC_W     = 10,
    parameter int unsigned BOOT_CODE = 440
) (
    input logic             clk,
    input logic             rst,
    input logic             por_good,
    input logic             en,
    input logic             en_strap,
    input logic             us_tick,
    input logic [DAC_W-1:0] dac_code,
    input logic             clk_en_n,
    input logic             pgood
);
    // R7: supply loss clears everything on the next clock
    a_r7_por_loss_clears: assert property (@(posedge clk) disable iff (rst)
        !por_good |=> (dac_code == '0) && clk_en_n && !pgood);

    // R7: enable loss (not strapped) clears everything on the next clock
    a_r7_en_loss_clears: assert property (@(posedge clk) disable iff (rst)
        (!en && !en_strap) |=> (dac_code == '0) && clk_en_n && !pgood);

    // R9: boot level is a ceiling until qualification
    a_r9_boot_ceiling: assert property (@(posedge clk) disable iff (rst)
        clk_en_n |-> (32'(dac_code) <= BOOT_CODE));

    // R2: before qualification the code only moves on a tick (or clears)
    a_r2_no_move_without_tick: assert property (@(posedge clk) disable iff (rst)
        (clk_en_n && !us_tick) |=> ((dac_code == $past(dac_code)) || (dac_code == '0)));

    // R5: tracking never jumps by more than two steps
    a_r5_step_limit: assert property (@(posedge clk) disable iff (rst)
        !clk_en_n |=> (clk_en_n ||
            (((int'(dac_code) - int'($past(dac_code))) <= 2) &&
             ((int'(dac_code) - int'($past(dac_code))) >= -2))));

    // R4: clock-enable holds while the request stays valid
    a_r4_clken_holds: assert property (@(posedge clk) disable iff (rst)
        (!clk_en_n && por_good && (en || en_strap)) |=> !clk_en_n);

    // R8: power-good implies clock-enable, and it is sticky
    a_r8_pgood_needs_clken: assert property (@(posedge clk) disable iff (rst)
        pgood |-> !clk_en_n);

    a_r8_pgood_sticky: assert property (@(posedge clk) disable iff (rst)
        (pgood && por_good && (en || en_strap)) |=> pgood);
endmodule

bind vr_startup_seq vr_startup_seq_chk #(
    .DAC_W     (DAC_W),
    .BOOT_CODE (BOOT_CODE)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .por_good (por_good),
    .en       (en),
    .en_strap (en_strap),
    .us_tick  (us_tick),
    .dac_code (dac_code),
    .clk_en_n (clk_en_n),
    .pgood    (pgood)
);

// File: tb/test_vr_startup_seq.sv
module test_vr_startup_seq;
    localparam int unsigned DW   = 8;
    localparam int unsigned BOOT = 10;
    localparam int unsigned QUAL = 4;
    localparam int unsigned STRP = 5;
    localparam int unsigned PGT  = 40;

    // {vid, ticks, expected dac}
    localparam logic [23:0] TRACK_TBL [0:9] = '{
        {8'd30, 8'd1,  8'd12},
        {8'd30, 8'd9,  8'd30},
        {8'd30, 8'd3,  8'd30},
        {8'd25, 8'd2,  8'd26},
        {8'd25, 8'd1,  8'd25},
        {8'd26, 8'd1,  8'd26},
        {8'd60, 8'd5,  8'd36},
        {8'd60, 8'd10, 8'd56},
        {8'd60, 8'd2,  8'd60},
        {8'd0,  8'd1,  8'd58}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          por_good = 1'b0;
    logic          en = 1'b0;
    logic          en_strap = 1'b0;
    logic          us_tick = 1'b0;
    logic          pwm_pulse = 1'b0;
    logic          in_window = 1'b0;
    logic [DW-1:0] vid_code = '0;
    logic [DW-1:0] dac_code;
    logic          clk_en_n;
    logic          pgood;

    int checks = 0;
    int fails  = 0;
    int tick_total = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    vr_startup_seq #(
        .DAC_W(DW), .BOOT_CODE(BOOT), .QUAL_CYCLES(QUAL),
        .STRAP_TICKS(STRP), .PGOOD_TICKS(PGT)
    ) i_vr_startup_seq (
        .clk(clk), .rst(rst), .por_good(por_good), .en(en), .en_strap(en_strap),
        .us_tick(us_tick), .pwm_pulse(pwm_pulse), .in_window(in_window),
        .vid_code(vid_code), .dac_code(dac_code), .clk_en_n(clk_en_n), .pgood(pgood)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", checks - fails, checks);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            us_tick = 1'b1;
            @(negedge clk);
            us_tick = 1'b0;
            tick_total++;
        end
    endtask

    task automatic pulse(input logic win);
        in_window = win;
        pwm_pulse = 1'b1;
        @(negedge clk);
        pwm_pulse = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        wait_clk(3);
        check("R1 reset dac", dac_code, 0);
        check("R1 reset clk_en_n", clk_en_n, 1);
        check("R1 reset pgood", pgood, 0);
        rst = 1'b0;

        // R1: por good but no enable: ticks do nothing
        por_good = 1'b1;
        do_ticks(4);
        check("R1 no enable dac", dac_code, 0);

        // R2: soft-start
        en = 1'b1;
        vid_code = 8'd30;
        wait_clk(1);
        tick_total = 0;
        do_ticks(3);
        check("R2 soft step", dac_code, 3);
        do_ticks(7);
        check("R2 reach boot", dac_code, BOOT);
        do_ticks(2);
        check("R2 hold at boot", dac_code, BOOT);
        check("R3 clk_en_n before qual", clk_en_n, 1);

        // R3: qualification with a restart
        for (int i = 0; i < 3; i++) pulse(1'b1);
        pulse(1'b0);
        wait_clk(1);
        check("R3 restart after out-of-window", clk_en_n, 1);
        for (int i = 0; i < 3; i++) pulse(1'b1);
        wait_clk(1);
        check("R3 short run not enough", clk_en_n, 1);
        pulse(1'b1);
        check("R4 not yet low", clk_en_n, 1);
        wait_clk(1);
        check("R4 clk_en_n low", clk_en_n, 0);
        check("R5 dac before first slew tick", dac_code, BOOT);
        check("R8 pgood early", pgood, 0);

        // R5/R8: table-driven tracking
        for (int k = 0; k < 10; k++) begin
            vid_code = TRACK_TBL[k][23:16];
            do_ticks(int'(TRACK_TBL[k][15:8]));
            check($sformatf("R5 row %0d dac", k), dac_code, int'(TRACK_TBL[k][7:0]));
            check($sformatf("R8 row %0d pgood", k), pgood, (tick_total >= PGT) ? 1 : 0);
        end
        check("R4 still low", clk_en_n, 0);

        // R7: enable loss
        en = 1'b0;
        wait_clk(1);
        check("R7 en loss dac", dac_code, 0);
        check("R7 en loss clk_en_n", clk_en_n, 1);
        check("R7 en loss pgood", pgood, 0);
        por_good = 1'b0;
        en_strap = 1'b1;
        do_ticks(3);
        check("R1 strap without por", dac_code, 0);

        // R6: strap delayed start, en ignored
        por_good = 1'b1;
        wait_clk(1);
        do_ticks(STRP - 1);
        wait_clk(1);
        check("R6 delay in progress", dac_code, 0);
        do_ticks(1);
        wait_clk(1);
        check("R6 delay last tick", dac_code, 0);
        do_ticks(1);
        check("R6 soft-start begins", dac_code, 1);
        do_ticks(2);
        check("R6 ramp continues", dac_code, 3);

        // R7: por loss in strap mode
        por_good = 1'b0;
        wait_clk(1);
        check("R7 por loss dac", dac_code, 0);
        check("R7 por loss clk_en_n", clk_en_n, 1);

        // R1: synchronous reset mid-ramp
        por_good = 1'b1;
        wait_clk(1);
        do_ticks(STRP);
        wait_clk(1);
        do_ticks(2);
        check("R2 strap ramp", dac_code, 2);
        rst = 1'b1;
        wait_clk(1);
        check("R1 sync reset dac", dac_code, 0);
        check("R1 sync reset clk_en_n", clk_en_n, 1);
        rst = 1'b0;
        wait_clk(2);

        summary();
        $finish;
    end
endmodule